// File: doc/BRIEF.md
# Pulse-by-Pulse Overcurrent Gate

This block sits between the PWM comparator and the output drivers of a fixed-frequency switching controller. It passes the raw PWM pulse through a purely combinational path, so the leading edge reaches the driver without waiting for a clock edge. While the pulse is being passed, it can be cut short by an overcurrent indication from either of two sense sources: a differential sense and a ground-referred sense. Once a pulse is cut, the output stays off until the oscillator signals the start of the next switching period.

A set/reset memory holds the limit condition. The OR of the two overcurrent flags sets it, and only the period-start strobe clears it. A second memory records that the gated output has already had a trailing edge in the current period, whatever caused that edge. Together these allow at most one output pulse per period, so a sense signal that chatters cannot turn the switch on again partway through a cycle. An external shutdown forces the output low while it is asserted.

The overcurrent and shutdown inputs arrive from outside the clock domain. Each passes through a synchroniser of `SYNC_STAGES` flops before use. The period strobe is a one-clock pulse that is already synchronous to `clk`. When a pulse is terminated by overcurrent, a one-clock event is raised.

Top module: `pbl_gate`

## Requirements
- R1: While no limit, no lockout and no shutdown is in effect, `pulse_o` equals `pwm_raw_i` in the same clock cycle, with no register in the path.
- R2: If an overcurrent input is raised while a pulse is being passed, `pulse_o` goes low once the synchronised flag is high. That is 2 rising clock edges after the raw input changes, for `SYNC_STAGES`=2, and it does not wait for the next period.
- R3: The differential sense (`oc_diff_i`) and the ground-referred sense (`oc_gnd_i`) each terminate a pulse on their own, because they are ORed into the limit memory's set input.
- R4: After an overcurrent cut, `pulse_o` stays low for the rest of the period, even if the overcurrent input drops or toggles while `pwm_raw_i` is still high.
- R5: A one-clock high on `period_strobe_i` with no overcurrent present clears the limit and the lockout. The next PWM pulse is then passed.
- R6: After any trailing edge of `pulse_o` in a period, a further PWM pulse in the same period is blocked.
- R7: While the synchronised `shutdown_i` is high, `pulse_o` is low. A pulse ended by shutdown does not resume in the same period after shutdown is released.
- R8: `cut_event_o` is high for exactly one clock, one edge after a pulse is cut by overcurrent. It stays low when a pulse ends because the PWM pulse ended, and when shutdown ends it.
- R9: If the period strobe and a synchronised overcurrent flag are sampled on the same clock edge, the set wins and the new period starts with the output inhibited.
- R10: After reset, with `pwm_raw_i` low, `pulse_o` and `cut_event_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_strobe_i | input | 1 | One-clock start-of-period strobe from the oscillator |
| pwm_raw_i | input | 1 | Raw PWM comparator pulse |
| oc_diff_i | input | 1 | Overcurrent flag, differential sense (asynchronous) |
| oc_gnd_i | input | 1 | Overcurrent flag, ground-referred sense (asynchronous) |
| shutdown_i | input | 1 | External shutdown, active high (asynchronous) |
| pulse_o | output | 1 | Gated pulse to the output drivers |
| cut_event_o | output | 1 | One-clock event: pulse terminated by overcurrent |

## Verification
The hardest case to reach is the tie in R9. The period strobe and the synchronised overcurrent flag must meet on one clock edge, and the flag must be low both before and after that edge. Otherwise the latch would simply be set at some other edge, and the priority would never be tested. The stimulus gets there with a raw overcurrent pulse that lasts one clock. It times the strobe to land on the one edge where that pulse leaves the synchroniser. A pulse raised in the following period then shows whether the period started inhibited. A second case is chatter after a cut. The overcurrent input is toggled while the PWM stays high, to show that the output does not come back.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  // Bit positions inside the synchronised flag vector.
  localparam int FLAG_OC_DIFF = 0;
  localparam int FLAG_OC_GND  = 1;
  localparam int FLAG_SHDN    = 2;
  localparam int FLAG_COUNT   = 3;
endpackage

// File: rtl/pbl_sync.sv
module pbl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d_i;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pbl_limit_latch.sv
module pbl_limit_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic lim_o
);
  logic lim_q;
  logic lim_d;
  logic lim_en;

  // Set dominates the period clear.
  always_comb begin
    lim_en = set_i | clr_i;
    lim_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= 1'b0;
    else if (lim_en) lim_q <= lim_d;
  end

  assign lim_o = lim_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> lim_o);

  // R5
  period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !lim_o);
endmodule

// File: rtl/pbl_period_lock.sv
module pbl_period_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic gate_i,
  output logic lock_o,
  output logic prev_o
);
  logic lock_q, lock_d;
  logic prev_q;
  logic fall;

  always_comb begin
    fall   = prev_q & ~gate_i;
    lock_d = (lock_q | fall) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
      prev_q <= gate_i;
    end
  end

  assign lock_o = lock_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pbl_gate.sv
module pbl_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_strobe_i,
  input  logic pwm_raw_i,
  input  logic oc_diff_i,
  input  logic oc_gnd_i,
  input  logic shutdown_i,
  output logic pulse_o,
  output logic cut_event_o
);
  import pbl_pkg::*;

  logic [FLAG_COUNT-1:0] raw_flags;
  logic [FLAG_COUNT-1:0] sync_flags;
  logic oc_any, shdn;
  logic lim, lock, gate_prev;
  logic cut_q, cut_d;

  assign raw_flags[FLAG_OC_DIFF] = oc_diff_i;
  assign raw_flags[FLAG_OC_GND]  = oc_gnd_i;
  assign raw_flags[FLAG_SHDN]    = shutdown_i;

  pbl_sync #(.WIDTH(FLAG_COUNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(raw_flags), .q_o(sync_flags)
  );

  assign oc_any = sync_flags[FLAG_OC_DIFF] | sync_flags[FLAG_OC_GND];
  assign shdn   = sync_flags[FLAG_SHDN];

  pbl_limit_latch limit_i (
    .clk(clk), .rst_n(rst_n), .set_i(oc_any), .clr_i(period_strobe_i),
    .lim_o(lim)
  );

  // Latency-free pass gate: the PWM edge reaches the output directly.
  assign pulse_o = pwm_raw_i & ~lim & ~oc_any & ~lock & ~shdn;

  pbl_period_lock lock_i (
    .clk(clk), .rst_n(rst_n), .clr_i(period_strobe_i), .gate_i(pulse_o),
    .lock_o(lock), .prev_o(gate_prev)
  );

  always_comb cut_d = pwm_raw_i & ~lim & ~lock & ~shdn & oc_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cut_q <= 1'b0;
    else        cut_q <= cut_d;
  end

  assign cut_event_o = cut_q;

  // R8
  cut_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cut_event_o |=> !cut_event_o);

  // R8
  cut_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cut_event_o |-> !pulse_o);

  // R6
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_prev && !pulse_o && !period_strobe_i) |=> !pulse_o);

  // R4
  limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim && !period_strobe_i) |=> !pulse_o);
endmodule

// File: tb/pbl_gate_tb.sv
module pbl_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_strobe_i = 1'b0;
  logic pwm_raw_i = 1'b0;
  logic oc_diff_i = 1'b0;
  logic oc_gnd_i = 1'b0;
  logic shutdown_i = 1'b0;
  logic pulse_o, cut_event_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pbl_gate #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_strobe_i(period_strobe_i),
    .pwm_raw_i(pwm_raw_i), .oc_diff_i(oc_diff_i), .oc_gnd_i(oc_gnd_i),
    .shutdown_i(shutdown_i), .pulse_o(pulse_o), .cut_event_o(cut_event_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic new_period();
    period_strobe_i = 1'b1;
    cyc(1);
    period_strobe_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 pulse after reset", pulse_o, 1'b0);
    chk("R10 event after reset", cut_event_o, 1'b0);
  endtask

  task automatic t_pass_and_lock();
    new_period();
    pwm_raw_i = 1'b1; #1;
    chk("R1 leading edge passes", pulse_o, 1'b1);
    cyc(3);
    chk("R1 pulse held", pulse_o, 1'b1);
    pwm_raw_i = 1'b0; #1;
    chk("R1 trailing edge", pulse_o, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cyc(1);
      chk("R8 no event on normal end", cut_event_o, 1'b0);
    end
    pwm_raw_i = 1'b1; #1;
    chk("R6 second pulse blocked", pulse_o, 1'b0);
    cyc(2);
    chk("R6 still blocked", pulse_o, 1'b0);
    pwm_raw_i = 1'b0;
    new_period();
  endtask

  task automatic t_oc(input bit use_gnd);
    string tag;
    tag = use_gnd ? "R3 ground sense" : "R3 differential sense";
    new_period();
    pwm_raw_i = 1'b1; #1;
    chk("R1 pulse before overcurrent", pulse_o, 1'b1);
    if (use_gnd) oc_gnd_i = 1'b1; else oc_diff_i = 1'b1;
    cyc(1);
    chk("R2 still high after one edge", pulse_o, 1'b1);
    cyc(1);
    chk(tag, pulse_o, 1'b0);
    chk("R2 cut within period", pulse_o, 1'b0);
    chk("R8 event not yet", cut_event_o, 1'b0);
    cyc(1);
    chk("R8 event raised", cut_event_o, 1'b1);
    cyc(1);
    chk("R8 event one clock", cut_event_o, 1'b0);
    // chatter on the sense input while PWM remains high
    for (int i = 0; i < 6; i++) begin
      oc_diff_i = i[0]; oc_gnd_i = 1'b0;
      cyc(1);
      chk("R4 no re-enable on chatter", pulse_o, 1'b0);
    end
    oc_diff_i = 1'b0; oc_gnd_i = 1'b0;
    cyc(4);
    chk("R4 held after overcurrent clears", pulse_o, 1'b0);
    pwm_raw_i = 1'b0;
    new_period();
    pwm_raw_i = 1'b1; #1;
    chk("R5 next period passes", pulse_o, 1'b1);
    cyc(1);
    pwm_raw_i = 1'b0;
    new_period();
  endtask

  task automatic t_tie();
    // one-clock raw pulse: synchronised flag is high only between edges 2 and 3
    oc_diff_i = 1'b1;
    cyc(1);
    oc_diff_i = 1'b0;
    cyc(1);
    period_strobe_i = 1'b1;
    cyc(1);
    period_strobe_i = 1'b0;
    cyc(2);
    pwm_raw_i = 1'b1; #1;
    chk("R9 period starts inhibited", pulse_o, 1'b0);
    cyc(1);
    pwm_raw_i = 1'b0;
    new_period();
    pwm_raw_i = 1'b1; #1;
    chk("R5 released next period", pulse_o, 1'b1);
    cyc(1);
    pwm_raw_i = 1'b0;
    new_period();
  endtask

  task automatic t_shutdown();
    new_period();
    pwm_raw_i = 1'b1; #1;
    chk("R7 pulse before shutdown", pulse_o, 1'b1);
    shutdown_i = 1'b1;
    cyc(2);
    chk("R7 forced off", pulse_o, 1'b0);
    cyc(1);
    chk("R8 no event for shutdown", cut_event_o, 1'b0);
    shutdown_i = 1'b0;
    cyc(4);
    chk("R7 no resume in period", pulse_o, 1'b0);
    pwm_raw_i = 1'b0;
    new_period();
    shutdown_i = 1'b1;
    cyc(3);
    pwm_raw_i = 1'b1; #1;
    chk("R7 blocked while asserted", pulse_o, 1'b0);
    pwm_raw_i = 1'b0;
    shutdown_i = 1'b0;
    cyc(3);
    new_period();
    pwm_raw_i = 1'b1; #1;
    chk("R5 passes after shutdown", pulse_o, 1'b1);
    pwm_raw_i = 1'b0;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_pass_and_lock();
    t_oc(1'b0);
    t_oc(1'b1);
    t_tie();
    t_shutdown();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule